// File: doc/BRIEF.md
# Transceiver Interrupt Status Controller

This block gathers interrupt events from a radio transceiver core and presents them to a host processor. Events latch into a 16-bit status register. A matching mask register selects which pending bits drive the active-low interrupt request. Both registers, plus a pad-control register and a timer-control register, sit behind a simple strobe-based read/write port that an SPI slave front end would drive. Reading the status register returns its contents and clears every bit in the same access. An event that arrives during that read is kept for the next read.

Timer compare matches set status bits 10 to 13. Each of these bits also clears when its compare-disable bit is set. The block has a small operation tracker for TX, RX and CCA. A PLL loss of lock during an operation latches a sticky status bit and forces the tracker back to idle. While that bit is pending, every new operation request is refused at once with an abort pulse.

The open-drain interrupt pad is modelled as an output enable with the pad value tied low. The pull-up enable and the drive-strength setting leave the block as plain control outputs.

Top module: `xcvr_irq_ctrl`

## Requirements
- R1: After reset the values are as follows. Status is 0x0000 and mask is 0xFFFF. The pad-control register holds pull-up enable 1 and drive strength 2'b11. The timer-control register is 0. The interrupt is released (irq_n_o=1, pad_oe_o=0), the operation state is idle (0) and op_abort_o is 0.
- R2: evt_i[k] set for one cycle sets status bit k at the next clock edge. This applies to every k except bits 4 and 10 to 13, where evt_i has no effect. The register map is: address 0 status (read only), 1 mask, 2 pad control, 3 timer control. Read data appears on rdata_o combinationally while rd_i is high, and is 0 otherwise.
- R3: irq_n_o is low exactly when some status bit is set and its mask bit is 0. A masked event still latches in status and reads back.
- R4: A read at address 0 returns the current status and clears all status bits at that clock edge. An event set in the same cycle survives and reads back afterwards.
- R5: Timer control bits [3:0] are compare-disable bits for timers 0 to 3. Writing a 1 to bit i clears status bit 10+i. While disable bit i is 1, tmr_match_i[i] is ignored. The bits appear on tmr_dis_o.
- R6: Status bit 11 is also set by tmr2_prime_i. Timer control bit 4 (wake mode, output tmr2_wake_o) blocks both sources of bit 11.
- R7: op_start_i with op_type_i 1 (TX), 2 (RX) or 3 (CCA), while the state is idle and status bit 4 is clear, moves op_state_o to that code. From idle, type 0 is ignored. op_done_i returns the state to idle. pll_unlock_i during a non-idle state sets status bit 4 and returns the state to idle. pll_unlock_i while idle has no effect.
- R8: While status bit 4 is set, a start request from idle with a nonzero type leaves the state idle and pulses op_abort_o high for one cycle at the next edge.
- R9: Pad control (address 2) holds the pull-up enable in bit 7 and drive strength in bits [1:0], which drive pull_en_o and drv_o.
- R10: pad_oe_o is high exactly when the interrupt is asserted. pad_o is always 0.
- R11: Writes to address 0 leave the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while rd_i is high |
| evt_i | input | 16 | General event pulses, one per status bit |
| tmr_match_i | input | 4 | Timer compare match pulses |
| tmr2_prime_i | input | 1 | Secondary compare match for timer 1 (status bit 11) |
| pll_unlock_i | input | 1 | PLL loss-of-lock indication |
| op_start_i | input | 1 | Operation start request |
| op_type_i | input | 2 | Requested operation: 1 TX, 2 RX, 3 CCA |
| op_done_i | input | 1 | Operation completed |
| op_state_o | output | 2 | Current operation, 0 idle |
| op_abort_o | output | 1 | One-cycle pulse on a refused start |
| irq_n_o | output | 1 | Active-low interrupt request |
| pad_oe_o | output | 1 | Open-drain pad output enable |
| pad_o | output | 1 | Pad output value, fixed 0 |
| pull_en_o | output | 1 | Internal pull-up enable |
| drv_o | output | 2 | Pad drive strength, 0 weakest |
| tmr_dis_o | output | 4 | Timer compare-disable bits |
| tmr2_wake_o | output | 1 | Timer 1 compare used as wake source |

## Verification
The hardest case to reach from the ports is a set and a clear landing on the same status bit in one cycle. This covers a new event during a status read, and a timer match in the same cycle as the write that disables that timer. It also covers a start request in the cycle where the PLL-unlock bit is being read away. Directed sequences place these on single cycles. A long random phase then drives sparse events, frequent reads, occasional control writes and random TX/RX/CCA traffic with PLL loss, so that these overlaps recur. Every cycle is compared against a bench model of the register map.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int DW      = 16;
  localparam int AW      = 2;
  localparam int NTMR    = 4;
  localparam int TMR_LSB = 10;
  localparam int PLL_BIT = 4;
  localparam int PUP_BIT = 7;
  localparam int DRV_W   = 2;

  localparam logic [AW-1:0] A_STAT = 2'd0;
  localparam logic [AW-1:0] A_MASK = 2'd1;
  localparam logic [AW-1:0] A_PAD  = 2'd2;
  localparam logic [AW-1:0] A_TCTL = 2'd3;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_TX   = 2'd1,
    OP_RX   = 2'd2,
    OP_CCA  = 2'd3
  } op_e;

  // bits driven by dedicated logic, not by evt_i
  function automatic logic [DW-1:0] rsvd_bits();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NTMR; i++) m[TMR_LSB+i] = 1'b1;
    m[PLL_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int W  = DW,
  parameter int AWD = AW,
  parameter int NT = NTMR
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_i,
  input  logic           wr_i,
  input  logic [AWD-1:0] addr_i,
  input  logic [W-1:0]   wdata_i,
  input  logic [W-1:0]   status_i,
  output logic [W-1:0]   mask_o,
  output logic           pup_o,
  output logic [DRV_W-1:0] drv_o,
  output logic [NT-1:0]  tdis_q_o,
  output logic [NT-1:0]  tdis_nxt_o,
  output logic           wake_q_o,
  output logic           wake_nxt_o,
  output logic [W-1:0]   rdata_o
);
  logic [W-1:0]       mask_q;
  logic               pup_q;
  logic [DRV_W-1:0]   drv_q;
  logic [NT-1:0]      tdis_q;
  logic               wake_q;
  logic               tctl_we;

  assign tctl_we    = wr_i && (addr_i == A_TCTL);
  assign tdis_nxt_o = tctl_we ? wdata_i[NT-1:0] : tdis_q;
  assign wake_nxt_o = tctl_we ? wdata_i[NT] : wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      pup_q  <= 1'b1;
      drv_q  <= '1;
      tdis_q <= '0;
      wake_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_MASK) mask_q <= wdata_i;
      if (wr_i && addr_i == A_PAD) begin
        pup_q <= wdata_i[PUP_BIT];
        drv_q <= wdata_i[DRV_W-1:0];
      end
      tdis_q <= tdis_nxt_o;
      wake_q <= wake_nxt_o;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_STAT: rdata_o = status_i;
        A_MASK: rdata_o = mask_q;
        A_PAD: begin
          rdata_o[PUP_BIT]     = pup_q;
          rdata_o[DRV_W-1:0]   = drv_q;
        end
        default: begin
          rdata_o[NT-1:0] = tdis_q;
          rdata_o[NT]     = wake_q;
        end
      endcase
    end
  end

  assign mask_o   = mask_q;
  assign pup_o    = pup_q;
  assign drv_o    = drv_q;
  assign tdis_q_o = tdis_q;
  assign wake_q_o = wake_q;
endmodule

// File: rtl/xirq_status.sv
module xirq_status
  import xirq_pkg::*;
#(
  parameter int W  = DW,
  parameter int NT = NTMR,
  parameter int TL = TMR_LSB,
  parameter int PB = PLL_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_clr_i,
  input  logic [W-1:0]  evt_i,
  input  logic [NT-1:0] tmr_match_i,
  input  logic          prime_i,
  input  logic [NT-1:0] tdis_nxt_i,
  input  logic          wake_nxt_i,
  input  logic          pll_hit_i,
  output logic [W-1:0]  status_o,
  output logic [W-1:0]  set_o
);
  localparam logic [W-1:0] RSVD = rsvd_bits();

  logic [NT-1:0] tset;
  logic [W-1:0]  set_v, clr_v, status_q;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic hit;
    if (i == 1) begin : g_dual
      assign hit = (tmr_match_i[i] | prime_i) & ~wake_nxt_i;
    end else begin : g_single
      assign hit = tmr_match_i[i];
    end
    assign tset[i] = hit & ~tdis_nxt_i[i];
  end

  always_comb begin
    set_v             = evt_i & ~RSVD;
    set_v[TL +: NT]   = tset;
    set_v[PB]         = pll_hit_i;
    clr_v             = '0;
    clr_v[TL +: NT]   = tdis_nxt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= ((rd_clr_i ? '0 : status_q) & ~clr_v) | set_v;
  end

  assign status_o = status_q;
  assign set_o    = set_v;
endmodule

// File: rtl/xirq_opgate.sv
module xirq_opgate
  import xirq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] type_i,
  input  logic       done_i,
  input  logic       unlock_i,
  input  logic       pll_flag_i,
  output op_e        state_o,
  output logic       abort_o,
  output logic       pll_hit_o
);
  op_e  state_q, state_d;
  logic abort_d, abort_q;

  assign pll_hit_o = (state_q != OP_IDLE) && unlock_i;

  always_comb begin
    state_d = state_q;
    abort_d = 1'b0;
    if (state_q != OP_IDLE) begin
      if (unlock_i || done_i) state_d = OP_IDLE;
    end else if (start_i && type_i != 2'd0) begin
      if (pll_flag_i) abort_d = 1'b1;
      else            state_d = op_e'(type_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OP_IDLE;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
    end
  end

  assign state_o = state_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/xcvr_irq_ctrl.sv
module xcvr_irq_ctrl
  import xirq_pkg::*;
#(
  parameter int W  = DW,
  parameter int AWD = AW,
  parameter int NT = NTMR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [AWD-1:0]   addr_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  input  logic [W-1:0]     evt_i,
  input  logic [NT-1:0]    tmr_match_i,
  input  logic             tmr2_prime_i,
  input  logic             pll_unlock_i,
  input  logic             op_start_i,
  input  logic [1:0]       op_type_i,
  input  logic             op_done_i,
  output logic [1:0]       op_state_o,
  output logic             op_abort_o,
  output logic             irq_n_o,
  output logic             pad_oe_o,
  output logic             pad_o,
  output logic             pull_en_o,
  output logic [DRV_W-1:0] drv_o,
  output logic [NT-1:0]    tmr_dis_o,
  output logic             tmr2_wake_o
);
  logic [W-1:0]  status_q, set_vec, mask_q;
  logic [NT-1:0] tdis_q, tdis_nxt;
  logic          wake_nxt, pll_hit, rd_clr;
  op_e           op_state;

  assign rd_clr = rd_i && (addr_i == A_STAT);

  xirq_regs #(.W(W), .AWD(AWD), .NT(NT)) u_regs (
    .clk_i, .rst_ni, .rd_i, .wr_i, .addr_i, .wdata_i,
    .status_i   (status_q),
    .mask_o     (mask_q),
    .pup_o      (pull_en_o),
    .drv_o      (drv_o),
    .tdis_q_o   (tdis_q),
    .tdis_nxt_o (tdis_nxt),
    .wake_q_o   (tmr2_wake_o),
    .wake_nxt_o (wake_nxt),
    .rdata_o    (rdata_o)
  );

  xirq_status #(.W(W), .NT(NT)) u_stat (
    .clk_i, .rst_ni,
    .rd_clr_i    (rd_clr),
    .evt_i       (evt_i),
    .tmr_match_i (tmr_match_i),
    .prime_i     (tmr2_prime_i),
    .tdis_nxt_i  (tdis_nxt),
    .wake_nxt_i  (wake_nxt),
    .pll_hit_i   (pll_hit),
    .status_o    (status_q),
    .set_o       (set_vec)
  );

  xirq_opgate u_op (
    .clk_i, .rst_ni,
    .start_i    (op_start_i),
    .type_i     (op_type_i),
    .done_i     (op_done_i),
    .unlock_i   (pll_unlock_i),
    .pll_flag_i (status_q[PLL_BIT]),
    .state_o    (op_state),
    .abort_o    (op_abort_o),
    .pll_hit_o  (pll_hit)
  );

  assign op_state_o = op_state;
  assign irq_n_o    = ~|(status_q & ~mask_q);
  assign pad_oe_o   = ~irq_n_o;
  assign pad_o      = 1'b0;
  assign tmr_dis_o  = tdis_q;
endmodule

// File: rtl/xirq_chk.sv
module xirq_chk
  import xirq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] set_vec,
  input logic [DW-1:0] mask_q,
  input logic [NTMR-1:0] tdis_q,
  input logic          irq_n_o,
  input logic [1:0]    op_state_o,
  input logic          op_abort_o,
  input logic          op_start_i,
  input logic [1:0]    op_type_i,
  input logic          pll_unlock_i
);
  // R2
  set_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vec != '0 |=> (status_q & $past(set_vec)) == $past(set_vec));

  // R4
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == A_STAT |=> status_q == $past(set_vec));

  // R3
  all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == '1 |-> irq_n_o);

  // R5
  tmr_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[TMR_LSB +: NTMR] & tdis_q) == '0);

  // R7
  pll_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_state_o != 2'd0 && pll_unlock_i |=> op_state_o == 2'd0 && status_q[PLL_BIT]);

  // R8
  op_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_state_o == 2'd0 && op_start_i && op_type_i != 2'd0 && status_q[PLL_BIT]
    |=> op_abort_o && op_state_o == 2'd0);

  // R11
  stat_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !rd_i && addr_i == A_STAT && set_vec == '0 |=> $stable(status_q));
endmodule

bind xcvr_irq_ctrl xirq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_i         (rd_i),
  .wr_i         (wr_i),
  .addr_i       (addr_i),
  .status_q     (status_q),
  .set_vec      (set_vec),
  .mask_q       (mask_q),
  .tdis_q       (tdis_q),
  .irq_n_o      (irq_n_o),
  .op_state_o   (op_state_o),
  .op_abort_o   (op_abort_o),
  .op_start_i   (op_start_i),
  .op_type_i    (op_type_i),
  .pll_unlock_i (pll_unlock_i)
);

// File: tb/sim_xcvr_irq_ctrl.sv
module sim_xcvr_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        rd = 0, wr = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0, evt = 0;
  logic [3:0]  tm = 0;
  logic        prime = 0, pll = 0, start = 0, done = 0;
  logic [1:0]  otype = 0;
  logic [15:0] rdata;
  logic [1:0]  op_state, drv;
  logic        abort, irq_n, pad_oe, pad, pull;
  logic [3:0]  tdis;
  logic        wake;

  int n_chk = 0, n_fail = 0;
  string tag = "R2";

  // bench model
  logic [15:0] m_stat = 16'h0000, m_mask = 16'hFFFF;
  logic        m_pup = 1, m_wake = 0, m_abort = 0;
  logic [1:0]  m_drv = 2'b11, m_op = 0;
  logic [3:0]  m_dis = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_irq_ctrl u0 (
    .clk_i(clk), .rst_ni, .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .tmr_match_i(tm), .tmr2_prime_i(prime),
    .pll_unlock_i(pll), .op_start_i(start), .op_type_i(otype), .op_done_i(done),
    .op_state_o(op_state), .op_abort_o(abort), .irq_n_o(irq_n), .pad_oe_o(pad_oe),
    .pad_o(pad), .pull_en_o(pull), .drv_o(drv), .tmr_dis_o(tdis), .tmr2_wake_o(wake)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic chk(string t, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_rd(logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return m_mask;
      2'd2: return {8'h00, m_pup, 5'h00, m_drv};
      default: return {11'h000, m_wake, m_dis};
    endcase
  endfunction

  // R2 R5 R6 R7: bits set this cycle
  function automatic logic [15:0] f_set(logic [15:0] e, logic [3:0] t, logic p,
                                        logic [3:0] dis, logic wk, logic ph);
    logic [15:0] s;
    s = e & ~16'h3C10;
    s[10] = t[0] & ~dis[0];
    s[11] = (t[1] | p) & ~wk & ~dis[1];
    s[12] = t[2] & ~dis[2];
    s[13] = t[3] & ~dis[3];
    s[4]  = ph;
    return s;
  endfunction

  task automatic tick();
    logic [3:0] ndis;
    logic nwake, ph, nab;
    logic [1:0] nop;
    logic [15:0] nstat;
    #1;
    if (rd) chk(addr == 0 ? "R4" : tag, rdata, model_rd(addr));
    else    chk("R2", rdata, 16'h0);
    ndis = m_dis; nwake = m_wake;
    if (wr && addr == 2'd3) begin ndis = wdata[3:0]; nwake = wdata[4]; end
    ph = (m_op != 0) && pll;
    nstat = (((rd && addr == 0) ? 16'h0 : m_stat) & ~({12'h000, ndis} << 10))
            | f_set(evt, tm, prime, ndis, nwake, ph);
    nop = m_op; nab = 0;
    if (m_op != 0) begin
      if (pll || done) nop = 0;
    end else if (start && otype != 0) begin
      if (m_stat[4]) nab = 1;
      else           nop = otype;
    end
    @(posedge clk);
    m_stat = nstat; m_dis = ndis; m_wake = nwake; m_op = nop; m_abort = nab;
    if (wr && addr == 2'd1) m_mask = wdata;
    if (wr && addr == 2'd2) begin m_pup = wdata[7]; m_drv = wdata[1:0]; end
    @(negedge clk);
    chk("R3",  {15'h0, irq_n}, {15'h0, ~|(m_stat & ~m_mask)});
    chk("R10", {14'h0, pad_oe, pad}, {14'h0, |(m_stat & ~m_mask), 1'b0});
    chk("R7",  {14'h0, op_state}, {14'h0, m_op});
    chk("R8",  {15'h0, abort}, {15'h0, m_abort});
    chk("R9",  {13'h0, pull, drv}, {13'h0, m_pup, m_drv});
    chk("R5",  {11'h0, wake, tdis}, {11'h0, m_wake, m_dis});
    rd = 0; wr = 0; evt = 0; tm = 0; prime = 0; pll = 0; start = 0; done = 0;
  endtask

  task automatic do_rd(logic [1:0] a, string t);
    tag = t; rd = 1; addr = a; tick();
  endtask

  task automatic do_wr(logic [1:0] a, logic [15:0] d);
    wr = 1; addr = a; wdata = d; tick();
  endtask

  task automatic rd_expect(logic [1:0] a, logic [15:0] e, string t);
    rd = 1; addr = a; #1;
    chk(t, rdata, e);
    tick();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {14'h0, irq_n, pad_oe}, 16'h0002);
    chk("R1", {11'h0, pull, drv, op_state}, {11'h0, 1'b1, 2'b11, 2'b00});
    chk("R1", {11'h0, abort, tdis}, 16'h0);
    rst_ni = 1;
    @(negedge clk);
    rd_expect(2'd0, 16'h0000, "R1");
    rd_expect(2'd1, 16'hFFFF, "R1");
    rd_expect(2'd2, 16'h0083, "R1");

    // R3 masked event latches, no irq
    evt = 16'h0001; tick();
    chk("R3", {15'h0, irq_n}, 16'h1);
    rd_expect(2'd0, 16'h0001, "R2");
    do_wr(2'd1, 16'hFFFE);
    evt = 16'h0001; tick();
    chk("R3", {15'h0, irq_n}, 16'h0);
    chk("R10", {15'h0, pad_oe}, 16'h1);
    rd_expect(2'd0, 16'h0001, "R4");
    chk("R3", {15'h0, irq_n}, 16'h1);
    // R2 evt on reserved bits ignored
    evt = 16'h3C10; tick();
    rd_expect(2'd0, 16'h0000, "R2");

    // R4 event coincident with read
    evt = 16'h0001; tick();
    evt = 16'h0004; rd = 1; addr = 0; #1;
    chk("R4", rdata, 16'h0001);
    tick();
    rd_expect(2'd0, 16'h0004, "R4");

    // R11 status write ignored
    evt = 16'h0100; tick();
    do_wr(2'd0, 16'hFFFF);
    rd_expect(2'd0, 16'h0100, "R11");

    // R5 timer disable clears and blocks
    tm = 4'b0100; tick();
    tm = 4'b0001; tick();
    do_wr(2'd3, 16'h0004);
    tm = 4'b0100; tick();
    rd_expect(2'd0, 16'h0400, "R5");
    do_wr(2'd3, 16'h0000);

    // R6 prime sets bit 11, wake mode blocks it
    prime = 1; tick();
    rd_expect(2'd0, 16'h0800, "R6");
    do_wr(2'd3, 16'h0010);
    prime = 1; tick();
    tm = 4'b0010; tick();
    rd_expect(2'd0, 16'h0000, "R6");
    do_wr(2'd3, 16'h0000);

    // R7 PLL loss during TX
    pll = 1; tick();
    chk("R7", {14'h0, op_state}, 16'h0);
    start = 1; otype = 2'd1; tick();
    chk("R7", {14'h0, op_state}, 16'h1);
    pll = 1; tick();
    chk("R7", {14'h0, op_state}, 16'h0);
    // R8 refused start while flag set
    start = 1; otype = 2'd2; tick();
    chk("R8", {14'h0, op_state, abort, 1'b0}, 16'h0002);
    tick();
    chk("R8", {15'h0, abort}, 16'h0);
    rd_expect(2'd0, 16'h0010, "R7");
    start = 1; otype = 2'd3; tick();
    chk("R7", {14'h0, op_state}, 16'h3);
    done = 1; tick();
    chk("R7", {14'h0, op_state}, 16'h0);

    // R9 pad register
    do_wr(2'd2, 16'h0001);
    rd_expect(2'd2, 16'h0001, "R9");
    do_wr(2'd2, 16'h0082);

    // random phase
    for (int i = 0; i < 5000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      evt   = $urandom & $urandom & $urandom;
      tm    = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      prime = ($urandom_range(0, 9) == 0);
      pll   = ($urandom_range(0, 11) == 0);
      start = ($urandom_range(0, 3) == 0);
      otype = 2'($urandom);
      done  = ($urandom_range(0, 7) == 0);
      addr  = 2'($urandom);
      if (r < 25) begin rd = 1; tag = "R2"; end
      else if (r < 30) begin
        wr = 1; wdata = 16'($urandom);
        if (addr == 2'd3) wdata = wdata & 16'h001F & 16'($urandom);
      end
      else if (r < 33) begin rd = 1; wr = 1; wdata = 16'($urandom); tag = "R2"; end
      tick();
    end
    summary();
  end
endmodule